// File: doc/BRIEF.md
# Sampled Entropy Bit Collector

This block gathers random bits from a raw, oscillator-derived input and packs them into a 192-bit holding register. A programmable interval timer decides when the raw input is sampled. Each sample then either goes straight into the holding register or first passes through a Von Neumann pairing stage, which removes bias from the stream. Software or a neighbouring controller then reads the result as six 32-bit words.

Once 192 bits have been packed, the collector raises `valid` and freezes the register. It resumes from an empty count only after a clear or a restart pulse. While the source is enabled and the register is not yet full, `busy` reports that collection is running. Disabling the source pauses collection and keeps the bits gathered so far.

Top module: `entropy_collector`

## Requirements
- R1: When the source is enabled and `valid` is low, the raw input is sampled once every N clock cycles, where N is the interval value. The first sample is taken on the N-th rising edge after collection starts. An interval of 0 behaves as 1. The interval resets to 0x0000FFFF and is loaded from `ivl_wdata` on any cycle where `ivl_we` is 1.
- R2: While `src_en` is 0, no bits are collected, `busy` is 0, and the holding register and its bit count keep their values.
- R3: `valid` rises on the clock edge that accepts the 192nd bit since the last restart or clear, and never earlier.
- R4: `word_data` shows bits [32k+31:32k] of the holding register when `word_sel` = k, for k = 0 to 5. It reads 0 for `word_sel` values 6 and 7.
- R5: With `vn_bypass` = 1, every sample enters the holding register unchanged.
- R6: With `vn_bypass` = 0, samples are grouped into non-overlapping pairs. The pair (first = 1, second = 0) yields bit 1, the pair (0, 1) yields bit 0, and the pairs (0, 0) and (1, 1) yield nothing. A half-collected pair is dropped whenever collection stops, restarts or is cleared.
- R7: Each accepted bit shifts in at bit 0, so the earliest of the 192 bits ends at bit 191. The holding register does not change while `valid` is 1.
- R8: A pulse on `restart` zeroes the bit count, drops `valid`, restarts the interval timer and drops any pending pair. The stored data is not erased.
- R9: A pulse on `valid_clr` drops `valid` and zeroes the bit count, timer and pair state, so collection resumes from a count of zero.
- R10: `busy` equals `src_en` AND NOT `valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 1 | Entropy source enable |
| ivl_we | input | 1 | Load strobe for the sample interval |
| ivl_wdata | input | 32 | New sample interval in clock cycles |
| vn_bypass | input | 1 | 1 = skip the pairing stage |
| restart | input | 1 | Pulse: reset the collected-bit counter |
| valid_clr | input | 1 | Pulse: clear the valid flag and resume |
| raw_bit | input | 1 | Raw random bit from the oscillator source |
| word_sel | input | 3 | Holding-register word index |
| word_data | output | 32 | Selected 32-bit word of the holding register |
| valid | output | 1 | 192 bits collected |
| busy | output | 1 | Collection in progress |

## Verification
The embedded assertions check, on every cycle, a set of local invariants:
- the holding register stays frozen while `valid` is high;
- `valid` only rises with a full count of 192;
- the pairing stage emits only from a completed pair;
- back-to-back samples never occur with an interval above 1;
- nothing moves while the source is disabled.

Only the bench scenarios can show the end-to-end properties:
- exact sample timing for a given interval, including the 65535-cycle reset interval and the zero-as-one case;
- the bit-exact contents produced by the pairing rules and by bypass;
- the word ordering;
- the effect of restart and clear in the middle of a fill.

// File: rtl/ec_pkg.sv
package ec_pkg;

    // Outcome of pairing two consecutive samples
    typedef enum logic [1:0] {
        VN_IDLE      = 2'd0,
        VN_EMIT_ZERO = 2'd1,
        VN_EMIT_ONE  = 2'd2,
        VN_DROP      = 2'd3
    } vn_act_e;

    // Equal samples carry no information; otherwise the first sample is the output
    function automatic vn_act_e vn_decide(input logic first_s, input logic second_s);
        if (first_s == second_s) begin
            return VN_DROP;
        end
        return first_s ? VN_EMIT_ONE : VN_EMIT_ZERO;
    endfunction

endpackage

// File: rtl/ec_sample_timer.sv
module ec_sample_timer #(
    parameter int          IVL_W   = 32,
    parameter int unsigned IVL_RST = 32'h0000FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sync_clr,
    input  logic             ivl_we,
    input  logic [IVL_W-1:0] ivl_wdata,
    output logic             strobe
);

    typedef struct packed {
        logic [IVL_W-1:0] ivl;
        logic [IVL_W-1:0] cnt;
    } tmr_t;

    tmr_t st_q, st_d;
    logic [IVL_W-1:0] last_cyc;

    always_comb begin
        st_d = st_q;
        // An interval of zero behaves as one
        last_cyc = (st_q.ivl == '0) ? '0 : (st_q.ivl - IVL_W'(1));
        strobe   = run && !sync_clr && (st_q.cnt >= last_cyc);
        if (ivl_we) begin
            st_d.ivl = ivl_wdata;
        end
        if (!run || sync_clr || strobe) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + IVL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ivl <= IVL_W'(IVL_RST);
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: with a stable interval above one, samples are never on adjacent cycles
    a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && (st_q.ivl > IVL_W'(1)) && !ivl_we) |=> !strobe);

    // R2: a stopped collector restarts its interval count from zero
    a_r2_idle_zeroes_timer: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0));

endmodule

// File: rtl/ec_vn_pair.sv
module ec_vn_pair
    import ec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sync_clr,
    input  logic bypass,
    input  logic smp_vld,
    input  logic smp_bit,
    output logic bit_vld,
    output logic bit_val
);

    typedef struct packed {
        logic pend;
        logic first;
    } pair_t;

    pair_t   st_q, st_d;
    vn_act_e act;

    always_comb begin
        st_d = st_q;
        act  = VN_IDLE;
        if (!run || sync_clr || bypass) begin
            // A half-collected pair is dropped whenever the stream is interrupted
            st_d.pend = 1'b0;
        end else if (smp_vld) begin
            if (!st_q.pend) begin
                st_d.pend  = 1'b1;
                st_d.first = smp_bit;
            end else begin
                st_d.pend = 1'b0;
                act       = vn_decide(st_q.first, smp_bit);
            end
        end
        if (bypass) begin
            bit_vld = smp_vld;
            bit_val = smp_bit;
        end else begin
            bit_vld = (act == VN_EMIT_ZERO) || (act == VN_EMIT_ONE);
            bit_val = (act == VN_EMIT_ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: a debiased bit needs a stored first half of its pair
    a_r6_emit_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !bypass) |-> st_q.pend);

    // R6: pairs do not overlap: after an emit no half-pair remains
    a_r6_pair_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !bypass) |=> !st_q.pend);

endmodule

// File: rtl/ec_hold_reg.sv
module ec_hold_reg #(
    parameter int HOLD_BITS = 192,
    parameter int CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_clr,
    input  logic                 bit_vld,
    input  logic                 bit_val,
    output logic [HOLD_BITS-1:0] data,
    output logic                 full
);

    typedef struct packed {
        logic [HOLD_BITS-1:0] data;
        logic [CNT_W-1:0]     cnt;
        logic                 full;
    } hold_t;

    hold_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (sync_clr) begin
            st_d.cnt  = '0;
            st_d.full = 1'b0;
        end else if (bit_vld && !st_q.full) begin
            st_d.data = {st_q.data[HOLD_BITS-2:0], bit_val};
            st_d.cnt  = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == CNT_W'(HOLD_BITS - 1)) begin
                st_d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data = st_q.data;
    assign full = st_q.full;

    // R7: contents frozen while full
    a_r7_frozen_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !sync_clr) |=> $stable(st_q.data));

    // R3: full only ever rises with the whole count collected
    a_r3_full_at_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.full) |-> (st_q.cnt == CNT_W'(HOLD_BITS)));

    // R3: the bit count never exceeds the register size
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(HOLD_BITS));

endmodule

// File: rtl/entropy_collector.sv
module entropy_collector #(
    parameter int          HOLD_BITS = 192,
    parameter int          WORD_W    = 32,
    parameter int          IVL_W     = 32,
    parameter int unsigned IVL_RST   = 32'h0000FFFF,
    localparam int         N_WORDS   = HOLD_BITS / WORD_W,
    localparam int         SEL_W     = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_en,
    input  logic              ivl_we,
    input  logic [IVL_W-1:0]  ivl_wdata,
    input  logic              vn_bypass,
    input  logic              restart,
    input  logic              valid_clr,
    input  logic              raw_bit,
    input  logic [SEL_W-1:0]  word_sel,
    output logic [WORD_W-1:0] word_data,
    output logic              valid,
    output logic              busy
);

    localparam int CNT_W = $clog2(HOLD_BITS + 1);

    logic                 sync_clr;
    logic                 run;
    logic                 smp_vld;
    logic                 bit_vld;
    logic                 bit_val;
    logic                 full;
    logic [HOLD_BITS-1:0] hold_data;
    logic [WORD_W-1:0]    words [N_WORDS];

    assign sync_clr = restart || valid_clr;
    assign run      = src_en && !full;
    assign busy     = run;
    assign valid    = full;

    ec_sample_timer #(
        .IVL_W   (IVL_W),
        .IVL_RST (IVL_RST)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sync_clr  (sync_clr),
        .ivl_we    (ivl_we),
        .ivl_wdata (ivl_wdata),
        .strobe    (smp_vld)
    );

    ec_vn_pair u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sync_clr (sync_clr),
        .bypass   (vn_bypass),
        .smp_vld  (smp_vld),
        .smp_bit  (raw_bit),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val)
    );

    ec_hold_reg #(
        .HOLD_BITS (HOLD_BITS),
        .CNT_W     (CNT_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_clr (sync_clr),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .data     (hold_data),
        .full     (full)
    );

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        assign words[g] = hold_data[g*WORD_W +: WORD_W];
    end

    always_comb begin
        word_data = '0;
        for (int k = 0; k < N_WORDS; k++) begin
            if (word_sel == SEL_W'(k)) begin
                word_data = words[k];
            end
        end
    end

    // R2: a disabled source leaves the holding register untouched
    a_r2_idle_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_en && !sync_clr) |=> $stable(hold_data));

    // R8 / R9: restart or clear always drops valid on the next cycle
    a_r9_clear_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> !valid);

endmodule

// File: tb/sim_entropy_collector.sv
module sim_entropy_collector;

    localparam int MAXC = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_en = 1'b0;
    logic        ivl_we = 1'b0;
    logic [31:0] ivl_wdata = '0;
    logic        vn_bypass = 1'b0;
    logic        restart = 1'b0;
    logic        valid_clr = 1'b0;
    logic        raw_bit = 1'b0;
    logic [2:0]  word_sel = '0;
    logic [31:0] word_data;
    logic        valid;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    logic rb [MAXC];
    logic [191:0] snap;

    always #10 clk = ~clk;

    entropy_collector u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_en    (src_en),
        .ivl_we    (ivl_we),
        .ivl_wdata (ivl_wdata),
        .vn_bypass (vn_bypass),
        .restart   (restart),
        .valid_clr (valid_clr),
        .raw_bit   (raw_bit),
        .word_sel  (word_sel),
        .word_data (word_data),
        .valid     (valid),
        .busy      (busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Expected register image and valid edge from the requirements (R1, R5, R6, R7)
    task automatic model(input int n, input bit byp, output logic [191:0] img,
                         output int edge_at);
        int  neff = (n == 0) ? 1 : n;
        int  cnt = 0;
        bit  have = 0;
        logic first = 0;
        img = '0;
        edge_at = -1;
        for (int j = 0; j < MAXC; j++) begin
            if (((j + 1) % neff) == 0) begin
                bit push = 0;
                logic b = 0;
                if (byp) begin
                    push = 1; b = rb[j];
                end else if (!have) begin
                    have = 1; first = rb[j];
                end else begin
                    have = 0;
                    if (first != rb[j]) begin
                        push = 1; b = first;
                    end
                end
                if (push) begin
                    img = {img[190:0], b};
                    cnt++;
                    if (cnt == 192) begin
                        edge_at = j + 1;
                        return;
                    end
                end
            end
        end
    endtask

    task automatic read_all(output logic [191:0] img);
        for (int k = 0; k < 6; k++) begin
            word_sel = 3'(k);
            #1;
            img[32*k +: 32] = word_data;
        end
        word_sel = '0;
    endtask

    task automatic run_fill(input int n, input bit byp, input bit use_clr, input string req);
        logic [191:0] exp_img;
        logic [191:0] got;
        logic [191:0] later;
        int exp_edge;
        int seen = -1;
        for (int j = 0; j < MAXC; j++) rb[j] = 1'($urandom());
        model(n, byp, exp_img, exp_edge);
        @(negedge clk);
        src_en = 1'b0; vn_bypass = byp; ivl_we = 1'b1; ivl_wdata = 32'(n);
        @(negedge clk);
        ivl_we = 1'b0; src_en = 1'b1; restart = !use_clr; valid_clr = use_clr;
        @(negedge clk);
        restart = 1'b0; valid_clr = 1'b0;
        chk(valid == 1'b0, use_clr ? "R9" : "R8", "valid after clear pulse", 64'(valid), 0);
        for (int j = 0; j < MAXC; j++) begin
            raw_bit = rb[j];
            if (j == 0) chk(busy == 1'b1, "R10", "busy while collecting", 64'(busy), 1);
            @(negedge clk);
            if (valid) begin
                seen = j + 1;
                break;
            end
        end
        chk(seen == exp_edge, {req, " R3 R1"}, "edges until valid", 64'(seen), 64'(exp_edge));
        chk(busy == 1'b0, "R10", "busy when full", 64'(busy), 0);
        read_all(got);
        for (int k = 0; k < 6; k++) begin
            chk(got[32*k +: 32] == exp_img[32*k +: 32], {req, " R4 R7"}, $sformatf("word %0d", k),
                64'(got[32*k +: 32]), 64'(exp_img[32*k +: 32]));
        end
        for (int j = 0; j < 40; j++) begin
            raw_bit = 1'($urandom());
            @(negedge clk);
        end
        read_all(later);
        chk(later == got, "R7", "frozen while valid (word0)", 64'(later[31:0]), 64'(got[31:0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", n_chk, n_chk + 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid == 1'b0, "R3", "valid after reset", 64'(valid), 0);
        chk(busy == 1'b0, "R10", "busy after reset", 64'(busy), 0);
        chk(word_data == 32'h0, "R4", "word0 after reset", 64'(word_data), 0);

        // R1: reset interval of 0xFFFF cycles, bypass, raw held at 1
        src_en = 1'b1; vn_bypass = 1'b1; raw_bit = 1'b1;
        repeat (65534) @(posedge clk);
        @(negedge clk);
        chk(word_data == 32'h0, "R1", "no sample before 65535 edges", 64'(word_data), 0);
        @(posedge clk);
        @(negedge clk);
        chk(word_data == 32'h1, "R1", "first sample at edge 65535", 64'(word_data), 1);
        src_en = 1'b0;

        run_fill(1, 1'b1, 1'b0, "R5");
        run_fill(1, 1'b0, 1'b1, "R6 R9");
        run_fill(3, 1'b0, 1'b0, "R6 R1");
        run_fill(0, 1'b1, 1'b1, "R1 zero-interval");

        // R8: partial fill, then restart must recount from zero
        @(negedge clk);
        valid_clr = 1'b1; src_en = 1'b1; vn_bypass = 1'b1;
        @(negedge clk);
        valid_clr = 1'b0;
        for (int j = 0; j < 100; j++) begin
            raw_bit = 1'($urandom());
            @(negedge clk);
        end
        chk(valid == 1'b0, "R8", "partial fill not valid", 64'(valid), 0);
        run_fill(2, 1'b1, 1'b0, "R8");

        // R2: disabling the source pauses collection
        @(negedge clk);
        valid_clr = 1'b1; src_en = 1'b1; ivl_we = 1'b1; ivl_wdata = 32'd1;
        @(negedge clk);
        valid_clr = 1'b0; ivl_we = 1'b0;
        for (int j = 0; j < 50; j++) begin
            raw_bit = 1'($urandom());
            @(negedge clk);
        end
        src_en = 1'b0;
        @(negedge clk);
        read_all(snap);
        for (int j = 0; j < 300; j++) begin
            raw_bit = 1'($urandom());
            @(negedge clk);
        end
        begin
            logic [191:0] after;
            read_all(after);
            chk(after == snap, "R2", "data held while disabled", 64'(after[63:0]), 64'(snap[63:0]));
        end
        chk(busy == 1'b0, "R2", "busy low while disabled", 64'(busy), 0);
        chk(valid == 1'b0, "R2", "no completion while disabled", 64'(valid), 0);

        // R4: out-of-range word indices
        word_sel = 3'd6; #1;
        chk(word_data == 32'h0, "R4", "word_sel 6", 64'(word_data), 0);
        word_sel = 3'd7; #1;
        chk(word_data == 32'h0, "R4", "word_sel 7", 64'(word_data), 0);
        word_sel = '0;

        // Random mix of interval, bypass and clear method
        for (int t = 0; t < 4; t++) begin
            int  n = 1 + int'($urandom() % 4);
            bit  b = 1'($urandom());
            bit  c = 1'($urandom());
            run_fill(n, b, c, b ? "R5 random" : "R6 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule